// File: doc/BRIEF.md
# Task-Indexed Paged Address Translator

This block widens a 16-bit CPU address into a 21-bit physical address. The logical space is split into eight 8 kB pages, and the top three address bits select the page. The block keeps one mapping memory that holds a group of eight page entries for each of 256 tasks. An 8-bit task register picks which group is live. When translation is on, the block reads the entry at index task×8 + page. That entry becomes bits 20:13 of the physical address, and the 13-bit offset passes straight through.

A context switch costs one write to the task register, because every task's page set is already in the table. Software fills the table through a separate write port that takes a flat 11-bit index. Any number of entries may name the same physical page. When translation is off, the table is not used and the output is the logical address with zeros on top.

Top module: `task_page_xlate`

## Requirements
- R1: After reset, enable reads 0, the task register reads 0, and phys_addr equals log_addr with five zero bits on top.
- R2: While enable is 0, phys_addr is {5'b0, log_addr} whatever the table and task register hold.
- R3: While enable is 1, phys_addr[20:13] equals the table entry at index {task, log_addr[15:13]}, that is task×8 + page.
- R4: phys_addr[12:0] always equals log_addr[12:0].
- R5: A task_wr pulse loads task_din into the task register at that clock edge. Lookups from the next cycle on use the new task's group, and no table entry changes.
- R6: A map_wr pulse stores map_din at map_idx at that clock edge. The next access that selects that index returns the new value, and this includes the active task.
- R7: Different indices may hold the same entry value, and each one translates to that value independently.
- R8: An en_wr pulse loads en_din into the enable register at that clock edge.
- R9: The lookup is combinational, so phys_addr follows a log_addr change within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the enable and task registers |
| en_wr | input | 1 | Load strobe for the enable register |
| en_din | input | 1 | New enable value |
| task_wr | input | 1 | Load strobe for the task register |
| task_din | input | 8 | New task number |
| map_wr | input | 1 | Table write strobe |
| map_idx | input | 11 | Table index {task, page} |
| map_din | input | 8 | Table entry to store |
| log_addr | input | 16 | CPU logical address |
| phys_addr | output | 21 | Translated physical address |
| xlate_on | output | 1 | Current enable register |
| task_cur | output | 8 | Current task register |

## Verification
A corrupted table entry or a wrong task value appears at once on phys_addr[20:13]. It shows up on the first access to the affected page, in the same cycle, because there is no pipeline. An error in the index arithmetic, such as swapped task and page fields, shows up as an entry from a neighbouring group. A bench that fills every entry with distinct random values exposes it. A stuck enable register appears as an identity or non-identity high byte on the next access after the cycle that should have changed it.

// File: rtl/task_page_xlate.sv
module task_page_xlate #(
  parameter int LA_W    = 16,
  parameter int PAGE_W  = 3,
  parameter int TASK_W  = 8,
  parameter int ENTRY_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en_wr,
  input  logic                                 en_din,
  input  logic                                 task_wr,
  input  logic [TASK_W-1:0]                    task_din,
  input  logic                                 map_wr,
  input  logic [TASK_W+PAGE_W-1:0]             map_idx,
  input  logic [ENTRY_W-1:0]                   map_din,
  input  logic [LA_W-1:0]                      log_addr,
  output logic [ENTRY_W+LA_W-PAGE_W-1:0]       phys_addr,
  output logic                                 xlate_on,
  output logic [TASK_W-1:0]                    task_cur
);
  localparam int IDX_W   = TASK_W + PAGE_W;
  localparam int OFF_W   = LA_W - PAGE_W;
  localparam int PA_W    = ENTRY_W + OFF_W;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int ZPAD    = PA_W - LA_W;

  logic [ENTRY_W-1:0] map_mem [DEPTH];
  logic               en_q;
  logic [TASK_W-1:0]  task_q;
  logic [IDX_W-1:0]   rd_idx;
  logic [ENTRY_W-1:0] rd_entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      task_q <= '0;
    end else begin
      if (en_wr)   en_q   <= en_din;
      if (task_wr) task_q <= task_din;
    end
  end

  always_ff @(posedge clk)
    if (map_wr) map_mem[map_idx] <= map_din;

  assign rd_idx   = {task_q, log_addr[LA_W-1:OFF_W]};
  assign rd_entry = map_mem[rd_idx];

  assign phys_addr = en_q ? {rd_entry, log_addr[OFF_W-1:0]}
                          : {{ZPAD{1'b0}}, log_addr};
  assign xlate_on  = en_q;
  assign task_cur  = task_q;
endmodule

// File: rtl/task_page_xlate_chk.sv
module task_page_xlate_chk #(
  parameter int LA_W    = 16,
  parameter int PAGE_W  = 3,
  parameter int TASK_W  = 8,
  parameter int ENTRY_W = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           en_wr,
  input logic                           en_din,
  input logic                           task_wr,
  input logic [TASK_W-1:0]              task_din,
  input logic                           map_wr,
  input logic [TASK_W+PAGE_W-1:0]       map_idx,
  input logic [ENTRY_W-1:0]             map_din,
  input logic [LA_W-1:0]                log_addr,
  input logic [ENTRY_W+LA_W-PAGE_W-1:0] phys_addr,
  input logic                           xlate_on,
  input logic [TASK_W-1:0]              task_cur
);
  localparam int OFF_W = LA_W - PAGE_W;
  localparam int ZPAD  = ENTRY_W + OFF_W - LA_W;

  a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]);

  a_r2_identity_off: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_on |-> phys_addr == {{ZPAD{1'b0}}, log_addr});

  a_r5_task_load: assert property (@(posedge clk) disable iff (!rst_n)
    task_wr |=> task_cur == $past(task_din));

  a_r8_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> xlate_on == $past(en_din));

  a_r1_hold_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(xlate_on));

  a_r6_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr && xlate_on && !en_wr && !task_wr &&
     map_idx == {task_cur, log_addr[LA_W-1:OFF_W]})
    |=> ($stable(log_addr) -> phys_addr[ENTRY_W+OFF_W-1:OFF_W] == $past(map_din)));
endmodule

bind task_page_xlate task_page_xlate_chk #(
  .LA_W(LA_W), .PAGE_W(PAGE_W), .TASK_W(TASK_W), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_din(en_din),
  .task_wr(task_wr), .task_din(task_din), .map_wr(map_wr),
  .map_idx(map_idx), .map_din(map_din), .log_addr(log_addr),
  .phys_addr(phys_addr), .xlate_on(xlate_on), .task_cur(task_cur)
);

// File: tb/task_page_xlate_bench.sv
`timescale 1ns/1ps
module task_page_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 1'b0, en_din = 1'b0;
  logic        task_wr = 1'b0;
  logic [7:0]  task_din = '0;
  logic        map_wr = 1'b0;
  logic [10:0] map_idx = '0;
  logic [7:0]  map_din = '0;
  logic [15:0] log_addr = '0;
  logic [20:0] phys_addr;
  logic        xlate_on;
  logic [7:0]  task_cur;

  logic [7:0]  shadow [2048];
  logic        m_en;
  logic [7:0]  m_task;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  task_page_xlate u_task_page_xlate (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_din(en_din),
    .task_wr(task_wr), .task_din(task_din), .map_wr(map_wr),
    .map_idx(map_idx), .map_din(map_din), .log_addr(log_addr),
    .phys_addr(phys_addr), .xlate_on(xlate_on), .task_cur(task_cur)
  );

  function automatic logic [20:0] expect_pa(logic en, logic [7:0] t, logic [15:0] la);
    if (!en) return {5'b0, la};
    return {shadow[{t, la[15:13]}], la[12:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_map(logic [10:0] idx, logic [7:0] d);
    @(negedge clk);
    map_wr = 1'b1; map_idx = idx; map_din = d;
    @(negedge clk);
    map_wr = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic set_task(logic [7:0] t);
    @(negedge clk);
    task_wr = 1'b1; task_din = t;
    @(negedge clk);
    task_wr = 1'b0;
    m_task = t;
  endtask

  task automatic set_en(logic e);
    @(negedge clk);
    en_wr = 1'b1; en_din = e;
    @(negedge clk);
    en_wr = 1'b0;
    m_en = e;
  endtask

  task automatic probe(string req, logic [15:0] la);
    log_addr = la;
    #0.5;
    check(req, {11'b0, phys_addr}, {11'b0, expect_pa(m_en, m_task, la)});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_en = 1'b0; m_task = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'b0, xlate_on}, 32'd0);
    check("R1", {24'b0, task_cur}, 32'd0);
    probe("R1", 16'hBEEF);

    // fill the table with random entries; R2 identity holds throughout
    for (int i = 0; i < 2048; i++) put_map(i[10:0], 8'($urandom));
    for (int i = 0; i < 20; i++) probe("R2", 16'($urandom));

    // R8 enable load
    set_en(1'b1);
    check("R8", {31'b0, xlate_on}, 32'd1);

    // R3 and R4 random lookups under several tasks
    for (int k = 0; k < 12; k++) begin
      set_task(8'($urandom));
      check("R5", {24'b0, task_cur}, {24'b0, m_task});
      for (int i = 0; i < 24; i++) probe("R3", 16'($urandom));
    end

    // R3 corner tasks and pages; R4 offset extremes
    set_task(8'hFF);
    probe("R3", 16'hFFFF);
    probe("R4", 16'hE000);
    set_task(8'h00);
    probe("R3", 16'h0000);
    probe("R4", 16'h1FFF);

    // R9 combinational: all pages in one cycle without any edge
    @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      log_addr = {p[2:0], 13'h0ABC};
      #0.2;
      checks++;
      if (phys_addr !== expect_pa(1'b1, m_task, log_addr)) begin
        errors++;
        $display("FAIL R9: actual=%h expected=%h", phys_addr, expect_pa(1'b1, m_task, log_addr));
      end
    end

    // R6 write to the active task's live page is seen on the next access
    set_task(8'h42);
    probe("R6", 16'h6123);
    put_map({8'h42, 3'd3}, ~shadow[{8'h42, 3'd3}]);
    probe("R6", 16'h6123);
    // R5 switching task leaves the table unchanged
    set_task(8'h43);
    set_task(8'h42);
    probe("R5", 16'h6123);

    // R7 aliases: three indices share one value
    put_map({8'h10, 3'd0}, 8'hA5);
    put_map({8'h10, 3'd7}, 8'hA5);
    put_map({8'h99, 3'd2}, 8'hA5);
    set_task(8'h10);
    probe("R7", 16'h0004);
    probe("R7", 16'hE004);
    set_task(8'h99);
    probe("R7", 16'h4004);

    // R2 disabling restores identity even with translation data present
    set_en(1'b0);
    check("R8", {31'b0, xlate_on}, 32'd0);
    for (int i = 0; i < 16; i++) probe("R2", 16'($urandom));
    // R2 writes while off do not affect output
    put_map({8'h99, 3'd2}, 8'h3C);
    probe("R2", 16'h4004);
    set_en(1'b1);
    probe("R6", 16'h4004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule